// File: doc/BRIEF.md
# Three-Stage Pipeline Hazard Controller

This block is the control half of an in-order fetch, decode and execute pipeline. Each cycle the fetch port offers the decoded attributes of one instruction. The controller decides whether that instruction is accepted. It keeps a valid bit and the hazard-relevant attributes for the decode and execute stages, and it reports stall, squash and redirect decisions to the datapath, which is outside the block. The datapath then steers the program counter and the register file from these decisions.

Four situations change the normal one-instruction-per-cycle flow:

- A multi-register load keeps the execute stage for one cycle per register and freezes the stages behind it.
- When an instruction reads an address-generator register that the instruction just ahead of it writes, one bubble is inserted.
- Each branch carries its own mode bit. A squashing branch that is taken discards the younger instructions already in flight. A delayed branch lets its two following instructions complete before fetch moves to the target.
- A cycle counter and a retired-instruction counter let a testbench measure throughput and branch cost.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: While `rst_n` is low (asynchronous), both stages are empty. `stall`, `squash`, `redirect` and `retire` are 0, `cycles` and `retired` are 0, and `f_accept` is 0 when `f_valid` is 0.
- R2: With no hazard, a valid instruction offered at fetch is accepted (`f_accept`=1) in that cycle and retires (`retire`=1) two cycles later, so that one instruction retires per cycle.
- R3: An instruction in decode that reads address register `f_rd_idx` while the instruction in execute writes the same index gets exactly one bubble. For that cycle `stall`=1 and `f_accept`=0. The next cycle has `retire`=0. No bubble is inserted when the indices differ.
- R4: An instruction with `f_nregs`=N (N≥2) occupies execute for N cycles. `stall`=1 and `f_accept`=0 for the first N-1 of them, and `retire`=1 only in the last. N of 0 or 1 takes one cycle, and `f_nregs` is ignored on branches.
- R5: A branch in execute with `f_delay`=0 at fetch time and `ex_taken`=1 asserts `squash` and `redirect` in that cycle. It drops the decode instruction and the instruction offered at fetch (`f_accept`=0). The next retire comes three cycles after the branch retires.
- R6: A branch with `f_delay`=0 that resolves with `ex_taken`=0 causes neither `squash` nor `redirect`, and sequential flow continues.
- R7: A taken branch with `f_delay`=1 never squashes. `redirect` is asserted in the cycle in which the second instruction after the branch is accepted at fetch. That is the resolving cycle itself when the decode stage is full and fetch accepts in that cycle. Otherwise it is a later cycle, counted in accepted instructions.
- R8: `cycles` increments by one on every clock edge out of reset. `retired` increments by one on each edge at which `retire` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_valid | input | 1 | Fetch port holds an instruction |
| f_branch | input | 1 | Offered instruction is a branch |
| f_delay | input | 1 | Branch mode: 1 delayed, 0 squashing |
| f_agu_wr | input | 1 | Instruction writes an address register |
| f_agu_rd | input | 1 | Instruction reads an address register |
| f_wr_idx | input | AW | Address register written |
| f_rd_idx | input | AW | Address register read |
| f_nregs | input | NW | Registers moved by a multi-register load |
| ex_taken | input | 1 | Branch outcome of the branch in execute |
| f_accept | output | 1 | Offered instruction enters decode this cycle |
| stall | output | 1 | Decode and fetch hold this cycle |
| squash | output | 1 | Younger instructions are discarded |
| redirect | output | 1 | Next fetch comes from the branch target |
| retire | output | 1 | Execute completes an instruction this cycle |
| cycles | output | CW | Cycles since reset |
| retired | output | CW | Instructions retired since reset |

## Verification
One continuous instruction stream exercises each hazard in turn. A matching address-register pair is followed by a non-matching one, which separates a real interlock from a false one. A three-register load shows that the stall length follows the register count. The same squashing branch mode is tried taken and not taken, to separate the squash from plain flow. A delayed branch is run twice: once with its slot instructions already in flight, and once with fetch starved. This shows whether the redirect is counted in accepted instructions rather than cycles. Final counter values and a reset applied during a long load confirm the measurement and clearing behaviour.

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl #(
  parameter int AW = 2,
  parameter int NW = 3,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          f_valid,
  input  logic          f_branch,
  input  logic          f_delay,
  input  logic          f_agu_wr,
  input  logic          f_agu_rd,
  input  logic [AW-1:0] f_wr_idx,
  input  logic [AW-1:0] f_rd_idx,
  input  logic [NW-1:0] f_nregs,
  input  logic          ex_taken,
  output logic          f_accept,
  output logic          stall,
  output logic          squash,
  output logic          redirect,
  output logic          retire,
  output logic [CW-1:0] cycles,
  output logic [CW-1:0] retired
);

  localparam logic [NW-1:0] ONE = NW'(1);

  logic          d_v, d_br, d_dly, d_awr, d_ard;
  logic [AW-1:0] d_widx, d_ridx;
  logic [NW-1:0] d_cnt;
  logic          e_v, e_br, e_dly, e_awr;
  logic [AW-1:0] e_widx;
  logic [NW-1:0] e_cnt;
  logic [1:0]    pend;

  logic e_busy, interlock, resolve, taken_dly;
  logic [1:0] slots;

  assign e_busy    = e_v && (e_cnt > ONE);
  assign interlock = !e_busy && d_v && d_ard && e_v && e_awr && (d_ridx == e_widx);
  assign stall     = e_busy || interlock;
  assign resolve   = e_v && e_br && !e_busy;
  assign squash    = resolve && ex_taken && !e_dly;
  assign taken_dly = resolve && ex_taken && e_dly;
  assign f_accept  = f_valid && !stall && !squash;
  assign retire    = e_v && !e_busy;
  assign slots     = {1'b0, d_v} + {1'b0, f_accept};
  assign redirect  = squash
                   || (taken_dly && slots == 2'd2)
                   || (pend == 2'd1 && f_accept);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_v <= 1'b0; d_br <= 1'b0; d_dly <= 1'b0; d_awr <= 1'b0; d_ard <= 1'b0;
      d_widx <= '0; d_ridx <= '0; d_cnt <= ONE;
    end else if (squash) begin
      d_v <= 1'b0;
    end else if (!stall) begin
      d_v    <= f_valid;
      d_br   <= f_branch;
      d_dly  <= f_delay;
      d_awr  <= f_agu_wr;
      d_ard  <= f_agu_rd;
      d_widx <= f_wr_idx;
      d_ridx <= f_rd_idx;
      d_cnt  <= (f_branch || f_nregs == '0) ? ONE : f_nregs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_v <= 1'b0; e_br <= 1'b0; e_dly <= 1'b0; e_awr <= 1'b0;
      e_widx <= '0; e_cnt <= ONE;
    end else if (e_busy) begin
      e_cnt <= e_cnt - ONE;
    end else if (squash || interlock) begin
      e_v <= 1'b0;
    end else begin
      e_v    <= d_v;
      e_br   <= d_br;
      e_dly  <= d_dly;
      e_awr  <= d_awr;
      e_widx <= d_widx;
      e_cnt  <= d_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pend <= 2'd0;
    else if (taken_dly && slots != 2'd2) pend <= 2'd2 - slots;
    else if (pend != 2'd0 && f_accept)   pend <= pend - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycles  <= '0;
      retired <= '0;
    end else begin
      cycles <= cycles + CW'(1);
      if (retire) retired <= retired + CW'(1);
    end
  end

  p_interlock_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    interlock |=> !interlock);
  p_interlock_bubble_r3: assert property (@(posedge clk) disable iff (!rst_n)
    interlock |=> !retire);
  p_stall_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !f_accept);
  p_squash_redirects_r5: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> (redirect && !f_accept));
  p_squash_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> !retire);
  p_retired_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (retired == $past(retired) + CW'(1)));
  p_cycles_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cycles == $past(cycles) + CW'(1)));

endmodule

// File: tb/tb_pipe_hazard_ctl.sv
module tb_pipe_hazard_ctl;
  localparam int AW = 2, NW = 3, CW = 32, NROW = 28;

  logic clk = 1'b0, rst_n = 1'b0;
  logic f_valid = 0, f_branch = 0, f_delay = 0, f_agu_wr = 0, f_agu_rd = 0, ex_taken = 0;
  logic [AW-1:0] f_wr_idx = '0, f_rd_idx = '0;
  logic [NW-1:0] f_nregs = '0;
  logic f_accept, stall, squash, redirect, retire;
  logic [CW-1:0] cycles, retired;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  pipe_hazard_ctl #(.AW(AW), .NW(NW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_branch(f_branch), .f_delay(f_delay),
    .f_agu_wr(f_agu_wr), .f_agu_rd(f_agu_rd), .f_wr_idx(f_wr_idx), .f_rd_idx(f_rd_idx),
    .f_nregs(f_nregs), .ex_taken(ex_taken), .f_accept(f_accept), .stall(stall),
    .squash(squash), .redirect(redirect), .retire(retire), .cycles(cycles), .retired(retired));

  // {valid,branch,delay,awr,ard}_{widx,ridx}_{nregs,taken}_{accept,stall,squash,redirect,retire}
  localparam logic [17:0] VEC [NROW] = '{
    18'b10000_0000_0000_10000,
    18'b10010_0100_0000_10000,
    18'b10001_0001_0000_10001,
    18'b10000_0000_0000_01001,
    18'b10000_0000_0000_10000,
    18'b10000_0000_0110_10001,
    18'b10010_1000_0000_10001,
    18'b10001_0011_0000_01000,
    18'b10001_0011_0000_01000,
    18'b10001_0011_0000_10001,
    18'b11000_0000_0000_10001,
    18'b10000_0000_0000_10001,
    18'b10000_0000_0001_00111,
    18'b10000_0000_0000_10000,
    18'b11100_0000_0000_10000,
    18'b10000_0000_0000_10001,
    18'b10000_0000_0001_10011,
    18'b11000_0000_0000_10001,
    18'b10000_0000_0000_10001,
    18'b11100_0000_0000_10001,
    18'b00000_0000_0000_00001,
    18'b00000_0000_0001_00001,
    18'b10000_0000_0000_10000,
    18'b10000_0000_0000_10010,
    18'b10000_0000_0000_10001,
    18'b00000_0000_0000_00001,
    18'b00000_0000_0000_00001,
    18'b00000_0000_0000_00000
  };

  function automatic string tag(input int i);
    if (i >= 2 && i <= 4)        return "R3";
    else if (i >= 5 && i <= 9)   return "R4";
    else if (i >= 10 && i <= 16) return (i >= 14) ? "R7" : "R5";
    else if (i >= 17 && i <= 19) return "R6";
    else if (i >= 20 && i <= 24) return "R7";
    return "R2";
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "accept", f_accept, 0);
    chk("R1", "stall", stall, 0);
    chk("R1", "squash/redirect", {squash, redirect}, 0);
    chk("R1", "retire", retire, 0);
    chk("R1", "cycles", cycles, 0);
    chk("R1", "retired", retired, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NROW; i++) begin
      {f_valid, f_branch, f_delay, f_agu_wr, f_agu_rd} = VEC[i][17:13];
      f_wr_idx = VEC[i][12:11];
      f_rd_idx = VEC[i][10:9];
      f_nregs  = VEC[i][8:6];
      ex_taken = VEC[i][5];
      #2;
      chk(tag(i), $sformatf("row %0d accept", i), f_accept, VEC[i][4]);
      chk(tag(i), $sformatf("row %0d stall", i), stall, VEC[i][3]);
      chk(tag(i), $sformatf("row %0d squash", i), squash, VEC[i][2]);
      chk(tag(i), $sformatf("row %0d redirect", i), redirect, VEC[i][1]);
      chk(tag(i), $sformatf("row %0d retire", i), retire, VEC[i][0]);
      @(negedge clk);
    end
    chk("R8", "cycles after stream", cycles, 28);
    chk("R8", "retired after stream", retired, 18);

    f_valid = 1'b1; f_nregs = 3'd4;
    #2; chk("R2", "long load accepted", f_accept, 1);
    @(negedge clk);
    f_valid = 1'b0; f_nregs = '0;
    @(negedge clk);
    #2; chk("R4", "long load stalls", stall, 1);
    rst_n = 1'b0;
    #1;
    chk("R1", "reset clears stall", stall, 0);
    chk("R1", "reset clears retire", retire, 0);
    chk("R1", "reset clears cycles", cycles, 0);
    chk("R1", "reset clears retired", retired, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule